// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the stack and vector-table traffic that a real-mode processor core needs when it takes an interrupt or returns from one. The core presents its live stack segment, stack pointer, code segment, instruction pointer and flag word, together with a one-cycle strobe. For an entry strobe it also presents an 8-bit vector type. The sequencer then performs every memory access on a single 16-bit word port with a request/ready handshake. When it finishes, the new register values are waiting on its outputs.

On entry the sequencer saves three words on the stack: the flag word, then the code segment, then the instruction pointer. In the live copy of the flags it clears the interrupt-enable bit and the single-step bit. It then reads the handler's instruction pointer and code segment from the vector table at the bottom of memory. On return it reads the same three words back in the mirrored order and restores them. Instruction decoding, arbitration between interrupt sources and all arithmetic outside the stack pointer are left to the surrounding core.

Top module: `irq_frame_seq`

## Requirements
- R1: After a synchronous reset `busy_o`, `done_o` and `mem_req_o` are 0, and `sp_o`, `cs_o`, `ip_o` and `flags_o` are 0.
- R2: A strobe accepted while idle raises `busy_o` in the next cycle. `busy_o` stays high, with `mem_req_o` high, until the last access of the operation completes. `busy_o` then falls in the same cycle that `done_o` shows a single one-cycle pulse.
- R3: Entry issues three writes, in this order. The entry flag word goes to stack offset SP-2, the entry code segment to SP-4, and the entry instruction pointer to SP-6, all in the stack segment. After entry `sp_o` equals SP-6.
- R4: The pushed flag word equals `flags_i` unchanged. After entry `flags_o` equals `flags_i` with bit 9 (interrupt enable) and bit 8 (single step) cleared and all other bits kept.
- R5: After the three pushes, entry reads the word at physical address type×4 into `ip_o`, then the word at type×4+2 into `cs_o`.
- R6: Return issues three reads in the stack segment. The word at offset SP goes to `ip_o`, the word at SP+2 to `cs_o`, and the word at SP+4 to `flags_o`. After return `sp_o` equals SP+6.
- R7: Every physical address is (segment×16 + offset) modulo 2^20, and stack offsets wrap modulo 2^16.
- R8: An access completes in a cycle with `mem_req_o` and `mem_rdy_i` both high. While ready is low the request, write enable, address and write data hold steady.
- R9: A take or return strobe that arrives while `busy_o` is high is ignored. No extra access happens, and the operation in progress completes with its original vector type.
- R10: When an entry strobe and a return strobe arrive in the same idle cycle, the entry is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | Interrupt entry strobe |
| vec_type_i | input | 8 | Vector type number for entry |
| ret_i | input | 1 | Interrupt return strobe |
| ss_i | input | 16 | Stack segment at the strobe |
| sp_i | input | 16 | Stack pointer at the strobe |
| cs_i | input | 16 | Code segment at the strobe |
| ip_i | input | 16 | Instruction pointer at the strobe |
| flags_i | input | 16 | Flag word at the strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 16 | Resulting stack pointer |
| cs_o | output | 16 | Resulting code segment |
| ip_o | output | 16 | Resulting instruction pointer |
| flags_o | output | 16 | Resulting flag word |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 20 | Physical byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with ready |
| mem_rdy_i | input | 1 | Access completes this cycle |

## Verification
An entry takes five handshakes and a return takes three. Each handshake lasts one cycle plus as many wait cycles as the memory model inserts. The memory model draws its ready signal at random, so completion time is unknown ahead of time. The bench therefore samples `busy_o` on the falling edge right after the strobe, where it must already be high. It then polls `done_o` on falling edges and compares all resulting registers on the edge where the pulse shows. The access order is recorded at each rising edge where a handshake completes and is compared after `done_o`. Ignored strobes are checked a few cycles later, by confirming that the access count has not moved and that `busy_o` stayed low.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_FLG,
    ST_PUSH_SEG,
    ST_PUSH_OFS,
    ST_VEC_OFS,
    ST_VEC_SEG,
    ST_POP_OFS,
    ST_POP_SEG,
    ST_POP_FLG
  } seq_state_t;

  function automatic logic is_push(input seq_state_t s);
    return (s == ST_PUSH_FLG) || (s == ST_PUSH_SEG) || (s == ST_PUSH_OFS);
  endfunction

  function automatic logic is_pop(input seq_state_t s);
    return (s == ST_POP_OFS) || (s == ST_POP_SEG) || (s == ST_POP_FLG);
  endfunction
endpackage

// File: rtl/irq_phys_addr.sv
module irq_phys_addr #(
  parameter int WORD_W  = 16,
  parameter int PHYS_W  = 20,
  parameter int SEG_SHL = 4
) (
  input  logic [WORD_W-1:0] seg_i,
  input  logic [WORD_W-1:0] ofs_i,
  output logic [PHYS_W-1:0] phys_o
);
  localparam int EXT_W = PHYS_W + 1;
  logic [EXT_W-1:0] seg_ext, ofs_ext, sum;

  generate
    if (EXT_W > WORD_W) begin : g_ext
      assign seg_ext = {{(EXT_W-WORD_W){1'b0}}, seg_i} << SEG_SHL;
      assign ofs_ext = {{(EXT_W-WORD_W){1'b0}}, ofs_i};
    end else begin : g_trunc
      assign seg_ext = seg_i[EXT_W-1:0] << SEG_SHL;
      assign ofs_ext = ofs_i[EXT_W-1:0];
    end
  endgenerate

  assign sum    = seg_ext + ofs_ext;
  assign phys_o = sum[PHYS_W-1:0];
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int TYPE_W  = 8,
  parameter int WORD_W  = 16,
  parameter int ENT_SHL = 2
) (
  input  logic [TYPE_W-1:0] type_i,
  input  logic              hi_word_i,
  output logic [WORD_W-1:0] ofs_o
);
  logic [WORD_W-1:0] base;
  assign base  = {{(WORD_W-TYPE_W){1'b0}}, type_i} << ENT_SHL;
  assign ofs_o = base | {{(WORD_W-2){1'b0}}, hi_word_i, 1'b0};
endmodule

// File: rtl/irq_stack_ptr.sv
module irq_stack_ptr #(
  parameter int WORD_W = 16,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_val_i,
  input  logic              dec_i,
  input  logic              inc_i,
  output logic [WORD_W-1:0] sp_o
);
  localparam logic [WORD_W-1:0] STEP_V = WORD_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst)         sp_o <= '0;
    else if (load_i) sp_o <= load_val_i;
    else if (dec_i)  sp_o <= sp_o - STEP_V;
    else if (inc_i)  sp_o <= sp_o + STEP_V;
  end

  AST_SP_ONE_DIR: assert property (@(posedge clk) disable iff (rst)
    !(dec_i && inc_i)); // R7
  AST_SP_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i) |=> (sp_o + STEP_V) == $past(sp_o)); // R7
  AST_SP_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i) |=> (sp_o - STEP_V) == $past(sp_o)); // R7
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_seq_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int PHYS_W  = 20,
  parameter int TYPE_W  = 8,
  parameter int SEG_SHL = 4,
  parameter int IE_BIT  = 9,
  parameter int ST_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [TYPE_W-1:0] vec_type_i,
  input  logic              ret_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] flags_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] flags_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PHYS_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i
);
  localparam int                STEP   = 2;
  localparam logic [WORD_W-1:0] STEP_V = WORD_W'(STEP);

  seq_state_t        st;
  logic [WORD_W-1:0] ss_r, cs_r, ip_r, flg_r;
  logic [TYPE_W-1:0] type_r;
  logic              busy_r, done_r;

  logic              start_take, start_ret, fire;
  logic              sp_load, sp_dec, sp_inc;
  logic [WORD_W-1:0] sp_load_val, sp_cur;
  logic              vec_phase;
  logic [WORD_W-1:0] vec_ofs, addr_seg, addr_ofs;
  logic [PHYS_W-1:0] phys;

  assign start_take = (st == ST_IDLE) && take_i;
  assign start_ret  = (st == ST_IDLE) && ret_i && !take_i;
  assign fire       = mem_req_o && mem_rdy_i;

  assign sp_load     = start_take || start_ret;
  assign sp_load_val = start_take ? (sp_i - STEP_V) : sp_i;
  assign sp_dec      = fire && ((st == ST_PUSH_FLG) || (st == ST_PUSH_SEG));
  assign sp_inc      = fire && is_pop(st);

  irq_stack_ptr #(.WORD_W(WORD_W), .STEP(STEP)) u_sp (
    .clk       (clk),
    .rst       (rst),
    .load_i    (sp_load),
    .load_val_i(sp_load_val),
    .dec_i     (sp_dec),
    .inc_i     (sp_inc),
    .sp_o      (sp_cur)
  );

  assign vec_phase = (st == ST_VEC_OFS) || (st == ST_VEC_SEG);

  irq_vec_addr #(.TYPE_W(TYPE_W), .WORD_W(WORD_W), .ENT_SHL(2)) u_vec (
    .type_i   (type_r),
    .hi_word_i(st == ST_VEC_SEG),
    .ofs_o    (vec_ofs)
  );

  assign addr_seg = vec_phase ? '0 : ss_r;
  assign addr_ofs = vec_phase ? vec_ofs : sp_cur;

  irq_phys_addr #(.WORD_W(WORD_W), .PHYS_W(PHYS_W), .SEG_SHL(SEG_SHL)) u_phys (
    .seg_i (addr_seg),
    .ofs_i (addr_ofs),
    .phys_o(phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ss_r   <= '0;
      cs_r   <= '0;
      ip_r   <= '0;
      flg_r  <= '0;
      type_r <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_take) begin
            ss_r   <= ss_i;
            cs_r   <= cs_i;
            ip_r   <= ip_i;
            flg_r  <= flags_i;
            type_r <= vec_type_i;
            busy_r <= 1'b1;
            st     <= ST_PUSH_FLG;
          end else if (start_ret) begin
            ss_r   <= ss_i;
            busy_r <= 1'b1;
            st     <= ST_POP_OFS;
          end
        end
        ST_PUSH_FLG: if (fire) begin
          flg_r[IE_BIT] <= 1'b0;
          flg_r[ST_BIT] <= 1'b0;
          st            <= ST_PUSH_SEG;
        end
        ST_PUSH_SEG: if (fire) st <= ST_PUSH_OFS;
        ST_PUSH_OFS: if (fire) st <= ST_VEC_OFS;
        ST_VEC_OFS: if (fire) begin
          ip_r <= mem_rdata_i;
          st   <= ST_VEC_SEG;
        end
        ST_VEC_SEG: if (fire) begin
          cs_r   <= mem_rdata_i;
          busy_r <= 1'b0;
          done_r <= 1'b1;
          st     <= ST_IDLE;
        end
        ST_POP_OFS: if (fire) begin
          ip_r <= mem_rdata_i;
          st   <= ST_POP_SEG;
        end
        ST_POP_SEG: if (fire) begin
          cs_r <= mem_rdata_i;
          st   <= ST_POP_FLG;
        end
        ST_POP_FLG: if (fire) begin
          flg_r  <= mem_rdata_i;
          busy_r <= 1'b0;
          done_r <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_wdata_o = '0;
    unique case (st)
      ST_PUSH_FLG: mem_wdata_o = flg_r;
      ST_PUSH_SEG: mem_wdata_o = cs_r;
      ST_PUSH_OFS: mem_wdata_o = ip_r;
      default:     mem_wdata_o = '0;
    endcase
  end

  assign mem_req_o  = (st != ST_IDLE);
  assign mem_we_o   = is_push(st);
  assign mem_addr_o = phys;
  assign busy_o     = busy_r;
  assign done_o     = done_r;
  assign sp_o       = sp_cur;
  assign cs_o       = cs_r;
  assign ip_o       = ip_r;
  assign flags_o    = flg_r;

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_rdy_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R8
  AST_BUSY_MEANS_REQ: assert property (@(posedge clk) disable iff (rst)
    busy_o == mem_req_o); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && $past(busy_o)); // R2
  AST_DONE_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R2
  AST_MASK_AFTER_SAVE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PUSH_SEG) |-> !flags_o[IE_BIT] && !flags_o[ST_BIT]); // R4
  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    vec_phase |-> (mem_addr_o >> (TYPE_W + 2)) == '0); // R5
  AST_BUSY_KEEPS_TYPE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> $stable(type_r) && $stable(ss_r)); // R9
endmodule

// File: tb/tb_irq_frame_seq.sv
`timescale 1ns/1ps
module tb_irq_frame_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        take_i, ret_i;
  logic [7:0]  vec_type_i;
  logic [15:0] ss_i, sp_i, cs_i, ip_i, flags_i;
  logic        busy_o, done_o, mem_req_o, mem_we_o, mem_rdy_i;
  logic [15:0] sp_o, cs_o, ip_o, flags_o, mem_wdata_o, mem_rdata_i;
  logic [19:0] mem_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_frame_seq dut (
    .clk(clk), .rst(rst), .take_i(take_i), .vec_type_i(vec_type_i), .ret_i(ret_i),
    .ss_i(ss_i), .sp_i(sp_i), .cs_i(cs_i), .ip_i(ip_i), .flags_i(flags_i),
    .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o), .cs_o(cs_o), .ip_o(ip_o),
    .flags_o(flags_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i)
  );

  logic [15:0] mem [0:8191];
  logic [19:0] log_addr [0:15];
  logic        log_we   [0:15];
  int          log_n = 0;
  int          hold_viol = 0;
  logic        prev_wait = 1'b0;
  logic [19:0] prev_addr = '0;

  assign mem_rdata_i = mem[mem_addr_o[13:1]];

  always @(posedge clk) begin
    if (mem_req_o && mem_rdy_i) begin
      if (mem_we_o) mem[mem_addr_o[13:1]] <= mem_wdata_o;
      if (log_n < 16) begin
        log_addr[log_n] <= mem_addr_o;
        log_we[log_n]   <= mem_we_o;
      end
      log_n <= log_n + 1;
    end
    if (prev_wait && (!mem_req_o || mem_addr_o != prev_addr)) hold_viol <= hold_viol + 1;
    prev_wait <= mem_req_o && !mem_rdy_i;
    prev_addr <= mem_addr_o;
  end

  always @(negedge clk) mem_rdy_i <= mem_req_o && (($urandom % 4) != 0);

  function automatic logic [15:0] vip(input logic [7:0] t);
    return {8'h5A ^ t, t};
  endfunction
  function automatic logic [15:0] vcs(input logic [7:0] t);
    return {t, 8'hC3} + 16'h0040;
  endfunction
  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] a;
    a = {1'b0, s, 4'h0} + {5'h0, o};
    return a[19:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fill_vectors();
    for (int t = 0; t < 256; t++) begin
      mem[t*2]   = vip(8'(t));
      mem[t*2+1] = vcs(8'(t));
    end
  endtask

  task automatic wait_done(input string req);
    int cyc = 0;
    while (!done_o && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk(done_o == 1'b1, req, "completion pulse", 32'(done_o), 32'd1);
    chk(busy_o == 1'b0, "R2", "busy low with done", 32'(busy_o), 32'd0);
  endtask

  task automatic do_take(input logic [7:0] t, input logic [15:0] s, input logic [15:0] p,
                         input logic [15:0] c, input logic [15:0] i, input logic [15:0] f,
                         input bit poke, input bit both, input bit chk_mem);
    logic [15:0] s2, s4, s6;
    s2 = p - 16'd2; s4 = p - 16'd4; s6 = p - 16'd6;
    @(negedge clk);
    log_n = 0;
    vec_type_i = t; ss_i = s; sp_i = p; cs_i = c; ip_i = i; flags_i = f;
    take_i = 1'b1; ret_i = both;
    @(negedge clk);
    take_i = 1'b0; ret_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after strobe", 32'(busy_o), 32'd1);
    if (poke) begin
      vec_type_i = t ^ 8'h55; ss_i = s ^ 16'h0F0F;
      take_i = 1'b1; ret_i = 1'b1;
      @(negedge clk);
      take_i = 1'b0; ret_i = 1'b0;
    end
    wait_done("R3");
    chk(log_n == 5, both ? "R10" : "R3", "entry access count", 32'(log_n), 32'd5);
    chk(log_addr[0] == phys(s, s2) && log_we[0], "R3", "flags push addr", 32'(log_addr[0]), 32'(phys(s, s2)));
    chk(log_addr[1] == phys(s, s4) && log_we[1], "R3", "cs push addr", 32'(log_addr[1]), 32'(phys(s, s4)));
    chk(log_addr[2] == phys(s, s6) && log_we[2], "R3", "ip push addr", 32'(log_addr[2]), 32'(phys(s, s6)));
    chk(log_addr[3] == {10'h0, t, 2'b00} && !log_we[3], "R5", "vector ip addr", 32'(log_addr[3]), 32'({t, 2'b00}));
    chk(log_addr[4] == {10'h0, t, 2'b10} && !log_we[4], "R5", "vector cs addr", 32'(log_addr[4]), 32'({t, 2'b10}));
    chk(ip_o == vip(t), "R5", "new ip", 32'(ip_o), 32'(vip(t)));
    chk(cs_o == vcs(t), "R5", "new cs", 32'(cs_o), 32'(vcs(t)));
    chk(flags_o == (f & 16'hFCFF), "R4", "masked flags", 32'(flags_o), 32'(f & 16'hFCFF));
    chk(sp_o == s6, "R3", "sp after entry", 32'(sp_o), 32'(s6));
    if (chk_mem) begin
      chk(mem[phys(s, s2) >> 1] == f, "R4", "saved flags", 32'(mem[phys(s, s2) >> 1]), 32'(f));
      chk(mem[phys(s, s4) >> 1] == c, "R3", "saved cs", 32'(mem[phys(s, s4) >> 1]), 32'(c));
      chk(mem[phys(s, s6) >> 1] == i, "R3", "saved ip", 32'(mem[phys(s, s6) >> 1]), 32'(i));
    end
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(log_n == 5, "R9", "no extra access", 32'(log_n), 32'd5);
      chk(busy_o == 1'b0, "R9", "stays idle", 32'(busy_o), 32'd0);
    end
  endtask

  task automatic do_ret(input logic [15:0] s, input logic [15:0] p, input logic [15:0] ei,
                        input logic [15:0] ec, input logic [15:0] ef);
    @(negedge clk);
    log_n = 0;
    ss_i = s; sp_i = p; ret_i = 1'b1;
    @(negedge clk);
    ret_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after return strobe", 32'(busy_o), 32'd1);
    wait_done("R6");
    chk(log_n == 3, "R6", "return access count", 32'(log_n), 32'd3);
    chk(log_addr[0] == phys(s, p) && !log_we[0], "R6", "pop ip addr", 32'(log_addr[0]), 32'(phys(s, p)));
    chk(log_addr[1] == phys(s, p + 16'd2) && !log_we[1], "R6", "pop cs addr", 32'(log_addr[1]), 32'(phys(s, p + 16'd2)));
    chk(log_addr[2] == phys(s, p + 16'd4) && !log_we[2], "R6", "pop flags addr", 32'(log_addr[2]), 32'(phys(s, p + 16'd4)));
    chk(ip_o == ei, "R6", "restored ip", 32'(ip_o), 32'(ei));
    chk(cs_o == ec, "R6", "restored cs", 32'(cs_o), 32'(ec));
    chk(flags_o == ef, "R6", "restored flags", 32'(flags_o), 32'(ef));
    chk(sp_o == p + 16'd6, "R6", "sp after return", 32'(sp_o), 32'(p + 16'd6));
  endtask

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4217));
    rst = 1'b1; take_i = 1'b0; ret_i = 1'b0; vec_type_i = '0;
    ss_i = '0; sp_i = '0; cs_i = '0; ip_i = '0; flags_i = '0;
    for (int k = 0; k < 8192; k++) mem[k] = '0;
    fill_vectors();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !mem_req_o, "R1", "idle after reset", {29'h0, busy_o, done_o, mem_req_o}, 32'd0);
    chk(sp_o == 0 && cs_o == 0 && ip_o == 0 && flags_o == 0, "R1", "regs after reset", 32'(sp_o | cs_o | ip_o | flags_o), 32'd0);

    // directed: plain entry and return with all flag bits set (R4)
    do_take(8'h21, 16'h0150, 16'h0800, 16'h1234, 16'h5678, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    do_ret(16'h0150, 16'h07FA, 16'h5678, 16'h1234, 16'hFFFF);
    // R9 strobes while busy
    do_take(8'h10, 16'h0120, 16'h0400, 16'hAAAA, 16'h5555, 16'h0302, 1'b1, 1'b0, 1'b1);
    // R10 simultaneous strobes
    do_take(8'h03, 16'h0130, 16'h0600, 16'h0001, 16'h0002, 16'h0200, 1'b0, 1'b1, 1'b1);
    // R7 stack offset wrap
    do_take(8'hFF, 16'h0200, 16'h0002, 16'hBEEF, 16'hCAFE, 16'h0100, 1'b0, 1'b0, 1'b0);
    do_ret(16'h0200, 16'hFFFC, 16'hCAFE, 16'hBEEF, 16'h0100);
    // R7 physical address wrap beyond 20 bits
    do_take(8'h84, 16'hFFFF, 16'h0012, 16'h0F0F, 16'hF0F0, 16'h0B00, 1'b0, 1'b0, 1'b0);
    do_ret(16'hFFFF, 16'h000C, 16'hF0F0, 16'h0F0F, 16'h0B00);
    fill_vectors();

    // random round trips
    for (int n = 0; n < 40; n++) begin
      logic [7:0]  t;
      logic [15:0] s, p, c, i, f;
      t = 8'($urandom);
      s = 16'h0100 + 16'($urandom % 256);
      p = 16'h0010 + 16'(2 * ($urandom % 2040));
      c = 16'($urandom); i = 16'($urandom); f = 16'($urandom);
      do_take(t, s, p, c, i, f, n % 7 == 0, 1'b0, 1'b1);
      do_ret(s, p - 16'd6, i, c, f);
    end

    // R8 request held during wait cycles
    chk(hold_viol == 0, "R8", "request stable while waiting", 32'(hold_viol), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule